// File: doc/BRIEF.md
# Stereo Clickless Attenuator with Mute and Silence Flag

This block sits in the sample path of a two-channel audio converter, ahead of interpolation. Once per frame, a strobe presents one left and one right 24-bit two's-complement sample. Each channel is multiplied by its own 14-bit unsigned linear gain, and the product is normalised so that the full-scale code passes the sample through unchanged. A phase-invert control negates both outputs, so the block can drive either an inverting or a non-inverting external filter.

The gain applied to a channel never jumps. It moves toward its target by one code per frame. A mute, requested from a hardware pin or from a control-register bit, sets both targets to zero. When the mute is removed, each channel ramps back to its stored gain word. A separate flag reports that both inputs have been silent for more than 1024 consecutive frames. A nonzero sample on either channel drops the flag at once.

Top module: `stereo_atten`

## Requirements
- R1: After reset, both outputs and the zero flag are 0. The applied gain of both channels is full scale (16383), so the first frame after reset passes its samples through unchanged, whatever the gain words are.
- R2: For each frame, each output is the channel sample times its applied gain G, divided by 16383 and rounded to nearest, with the magnitude rounded half away from zero: |out| = (|s|*G + 8191) / 16383. The result is saturated to the range -8388608..8388607. With G = 16383 the output equals the input.
- R3: The frame's output is registered at the strobe edge and uses the gain applied before that frame's ramp step. Outputs and applied gains change only on a strobe. On each strobe the applied gain moves by exactly one code toward its target, or holds if it already equals the target.
- R4: While mute_pin is 1, the target of both channels is 0, so both applied gains fall by one code per frame until they reach 0, and the outputs reach 0.
- R5: While mute_reg is 1, both channels are muted in the same way as by the pin.
- R6: When both mute inputs are 0, each channel's target is its gain word, and the applied gain ramps back up to that word one code per frame.
- R7: When invert is 1, each output is the negation of the scaled value. A result of +8388608 saturates to 8388607.
- R8: zero_flag rises at the strobe of the 1025th consecutive frame in which both samples are 0. It stays high while the silent frames continue.
- R9: A frame with a nonzero sample on either channel clears the silent-frame count and drops zero_flag at that frame's strobe. The next rise again needs 1025 silent frames.
- R10: The two channels ramp and scale independently. A gain word on one channel does not affect the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_stb | input | 1 | One-cycle strobe: a new sample pair is present |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| gain_l | input | 14 | Left target gain word, unsigned linear |
| gain_r | input | 14 | Right target gain word, unsigned linear |
| mute_pin | input | 1 | Hardware mute request, active high |
| mute_reg | input | 1 | Control-register mute request, active high |
| invert | input | 1 | Output phase inversion |
| left_out | output | 24 | Scaled left sample |
| right_out | output | 24 | Scaled right sample |
| zero_flag | output | 1 | Both inputs silent for more than 1024 frames |

## Verification
The assertions check the following on every cycle:
- Applied gains and outputs hold between strobes.
- Each strobe moves a gain by at most one code.
- A mute lowers a nonzero gain by exactly one code.
- Unity gain without inversion is transparent.
- A nonzero sample always clears the zero flag.
- The flag rises only at a strobe.

Some behaviour can only be shown by the bench's scenarios, which compare every frame against a model built from the requirements:
- the exact rounded value of a product;
- saturation of a negated full-scale sample;
- the full-scale gain right after reset;
- the complete ramps into and out of mute;
- the exact frame on which the flag rises.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int unsigned NUM_CH       = 2;
  localparam int unsigned DEF_DATA_W   = 24;
  localparam int unsigned DEF_GAIN_W   = 14;
  localparam int unsigned DEF_SILENT_N = 1024;

  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
endpackage

// File: rtl/atten_gain_ramp.sv
module atten_gain_ramp #(
  parameter int unsigned GAIN_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [GAIN_W-1:0] target,
  output logic [GAIN_W-1:0] gain
);
  logic [GAIN_W-1:0] gain_q, gain_d;

  always_comb begin
    gain_d = gain_q;
    if (step_en) begin
      if (gain_q < target)      gain_d = gain_q + 1'b1;
      else if (gain_q > target) gain_d = gain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain_q <= '1;
    else        gain_q <= gain_d;
  end

  assign gain = gain_q;
endmodule

// File: rtl/atten_scale.sv
module atten_scale #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned GAIN_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] sample,
  input  logic [GAIN_W-1:0] gain,
  input  logic              invert,
  output logic [DATA_W-1:0] result
);
  localparam int unsigned PROD_W = DATA_W + GAIN_W;
  localparam logic [PROD_W-1:0] UNITY   = {{DATA_W{1'b0}}, {GAIN_W{1'b1}}};
  localparam logic [PROD_W-1:0] HALF    = UNITY >> 1;
  localparam logic [PROD_W-1:0] POS_MAX = {{(GAIN_W+1){1'b0}}, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] mag;
  logic [PROD_W-1:0] prod, quot;
  logic              neg;
  logic [DATA_W-1:0] res_d, res_q;

  always_comb begin
    mag  = sample[DATA_W-1] ? (~sample + 1'b1) : sample;
    prod = PROD_W'(mag) * PROD_W'(gain);
    quot = (prod + HALF) / UNITY;
    neg  = sample[DATA_W-1] ^ invert;
    if (neg)               res_d = ~quot[DATA_W-1:0] + 1'b1;
    else if (quot > POS_MAX) res_d = POS_MAX[DATA_W-1:0];
    else                   res_d = quot[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_q <= '0;
    else if (load_en) res_q <= res_d;
  end

  assign result = res_q;
endmodule

// File: rtl/atten_silence_det.sv
module atten_silence_det #(
  parameter int unsigned SILENT_N = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_en,
  input  logic all_zero,
  output logic flag
);
  localparam int unsigned CNT_W = $clog2(SILENT_N + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SILENT_N);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (frame_en) begin
      if (!all_zero)            cnt_d = '0;
      else if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
      flag_d = all_zero && (cnt_q == CNT_TOP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/stereo_atten.sv
module stereo_atten
  import atten_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned GAIN_W   = DEF_GAIN_W,
  parameter int unsigned SILENT_N = DEF_SILENT_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] left_in,
  input  logic [DATA_W-1:0] right_in,
  input  logic [GAIN_W-1:0] gain_l,
  input  logic [GAIN_W-1:0] gain_r,
  input  logic              mute_pin,
  input  logic              mute_reg,
  input  logic              invert,
  output logic [DATA_W-1:0] left_out,
  output logic [DATA_W-1:0] right_out,
  output logic              zero_flag
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic              muted;
  logic [DATA_W-1:0] ch_in   [NUM_CH];
  logic [GAIN_W-1:0] ch_word [NUM_CH];
  logic [GAIN_W-1:0] ch_tgt  [NUM_CH];
  logic [GAIN_W-1:0] ch_gain [NUM_CH];
  logic [DATA_W-1:0] ch_out  [NUM_CH];
  logic [GAIN_W-1:0] app_gain_l, app_gain_r;

  assign muted            = mute_pin | mute_reg;
  assign ch_in[CH_LEFT]   = left_in;
  assign ch_in[CH_RIGHT]  = right_in;
  assign ch_word[CH_LEFT] = gain_l;
  assign ch_word[CH_RIGHT] = gain_r;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_tgt[c] = muted ? '0 : ch_word[c];

    atten_gain_ramp #(.GAIN_W(GAIN_W)) ramp_i (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .step_en (frame_stb),
      .target  (ch_tgt[c]),
      .gain    (ch_gain[c])
    );

    atten_scale #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) scale_i (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .load_en (frame_stb),
      .sample  (ch_in[c]),
      .gain    (ch_gain[c]),
      .invert  (invert),
      .result  (ch_out[c])
    );
  end

  atten_silence_det #(.SILENT_N(SILENT_N)) silence_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .frame_en (frame_stb),
    .all_zero ((left_in == '0) && (right_in == '0)),
    .flag     (zero_flag)
  );

  assign left_out   = ch_out[CH_LEFT];
  assign right_out  = ch_out[CH_RIGHT];
  assign app_gain_l = ch_gain[CH_LEFT];
  assign app_gain_r = ch_gain[CH_RIGHT];
endmodule

// File: rtl/atten_checker.sv
module atten_checker #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned GAIN_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_stb,
  input logic [DATA_W-1:0] left_in,
  input logic [DATA_W-1:0] right_in,
  input logic              mute_pin,
  input logic              mute_reg,
  input logic              invert,
  input logic [GAIN_W-1:0] gain_l,
  input logic [GAIN_W-1:0] gain_r,
  input logic [DATA_W-1:0] left_out,
  input logic [DATA_W-1:0] right_out,
  input logic              zero_flag
);
  localparam logic [GAIN_W-1:0] GMAX = '1;

  p_gain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(gain_l) && $stable(gain_r)));

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(left_out) && $stable(right_out)));

  p_gain_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> ((gain_l == $past(gain_l)) || (gain_l == $past(gain_l) + 1'b1) ||
                   (gain_l == $past(gain_l) - 1'b1)));

  p_mute_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && (mute_pin || mute_reg) && (gain_r != '0)) |=> (gain_r == $past(gain_r) - 1'b1));

  p_unity_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && (gain_l == GMAX) && !invert) |=> (left_out == $past(left_in)));

  p_zero_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && ((left_in != '0) || (right_in != '0))) |=> !zero_flag);

  p_flag_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_flag) |-> $past(frame_stb));
endmodule

bind stereo_atten atten_checker #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .frame_stb (frame_stb),
  .left_in   (left_in),
  .right_in  (right_in),
  .mute_pin  (mute_pin),
  .mute_reg  (mute_reg),
  .invert    (invert),
  .gain_l    (app_gain_l),
  .gain_r    (app_gain_r),
  .left_out  (left_out),
  .right_out (right_out),
  .zero_flag (zero_flag)
);

// File: tb/stereo_atten_tb_top.sv
module stereo_atten_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_stb;
  logic [23:0] left_in, right_in;
  logic [13:0] gain_l, gain_r;
  logic        mute_pin, mute_reg, invert;
  logic [23:0] left_out, right_out;
  logic        zero_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int mg [2];
  int zrun;

  always #5 clk = ~clk;

  stereo_atten dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .left_in(left_in), .right_in(right_in),
    .gain_l(gain_l), .gain_r(gain_r),
    .mute_pin(mute_pin), .mute_reg(mute_reg), .invert(invert),
    .left_out(left_out), .right_out(right_out), .zero_flag(zero_flag)
  );

  function automatic int scale(int s, int g, bit inv);
    longint mag, q;
    bit neg;
    mag = (s < 0) ? -longint'(s) : longint'(s);
    q   = (mag * g + 8191) / 16383;
    neg = (s < 0) ^ inv;
    if (neg) return int'(-q);
    return (q > 8388607) ? 8388607 : int'(q);
  endfunction

  function automatic int pat(int i);
    return ((i * 7919 + 12345) % 16777216) - 8388608;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step_model(int ch, int word);
    int tgt;
    tgt = (mute_pin || mute_reg) ? 0 : word;
    if (mg[ch] < tgt)      mg[ch]++;
    else if (mg[ch] > tgt) mg[ch]--;
  endtask

  task automatic do_frame(int l, int r, string tag);
    int el, er;
    el = scale(l, mg[0], invert);
    er = scale(r, mg[1], invert);
    @(negedge clk);
    left_in = l[23:0]; right_in = r[23:0]; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    check(tag, $signed(left_out), el);
    check(tag, $signed(right_out), er);
    if (l == 0 && r == 0) begin
      if (zrun < 1025) zrun++;
    end else zrun = 0;
    check((zrun > 0) ? "R8" : "R9", int'(zero_flag), (zrun > 1024) ? 1 : 0);
    step_model(0, int'(gain_l));
    step_model(1, int'(gain_r));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", int'(left_out), 0);
    check("R1", int'(right_out), 0);
    check("R1", int'(zero_flag), 0);
    gain_l = 14'd8192;
    do_frame(1234567, -7654321, "R1");
    gain_l = 14'd16383;
    do_frame(8388607, -8388608, "R2");
    do_frame(-1, 1, "R2");
  endtask

  task automatic t_ramp();
    int hl, hr;
    gain_l = 14'd16380;
    for (int i = 0; i < 6; i++) do_frame(1000000, 1000000, "R3");
    do_frame(-3000000, 2000000, "R10");
    hl = $signed(left_out); hr = $signed(right_out);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      left_in = 24'h123456; right_in = 24'h654321;
    end
    @(negedge clk);
    check("R3", $signed(left_out), hl);
    check("R3", $signed(right_out), hr);
    do_frame(500, 500, "R3");
  endtask

  task automatic t_scale();
    gain_l = 14'd16000;
    for (int i = 0; i < 420; i++) do_frame(pat(i), pat(i + 77), "R2");
    do_frame(1, -1, "R2");
    do_frame(8388607, 3, "R2");
  endtask

  task automatic t_invert();
    invert = 1'b1;
    do_frame(1000, -8388608, "R7");
    do_frame(-8388608, 8388607, "R7");
    do_frame(pat(5), pat(9), "R7");
    invert = 1'b0;
    do_frame(1000, -8388608, "R7");
  endtask

  task automatic t_zero();
    for (int i = 0; i < 1030; i++) do_frame(0, 0, "R8");
    do_frame(5, 0, "R9");
    for (int i = 0; i < 1026; i++) do_frame(0, 0, "R8");
    do_frame(0, -2, "R9");
    do_frame(0, 0, "R8");
  endtask

  task automatic t_mute_pin();
    mute_pin = 1'b1;
    for (int i = 0; i < 16400; i++) do_frame(pat(i), pat(i + 3), "R4");
    do_frame(8388607, -8388608, "R4");
    check("R4", int'(left_out), 0);
    check("R4", int'(right_out), 0);
  endtask

  task automatic t_unmute();
    gain_l = 14'd100; gain_r = 14'd50;
    mute_pin = 1'b0;
    for (int i = 0; i < 110; i++) do_frame(8388607, -8388608, "R6");
    do_frame(8388607, -8388608, "R6");
  endtask

  task automatic t_mute_reg();
    mute_reg = 1'b1;
    for (int i = 0; i < 105; i++) do_frame(8388607, 8388607, "R5");
    check("R5", int'(left_out), 0);
    check("R5", int'(right_out), 0);
    mute_reg = 1'b0;
    for (int i = 0; i < 4; i++) do_frame(8388607, 8388607, "R6");
  endtask

  initial begin
    rst_n = 1'b0; frame_stb = 1'b0; left_in = '0; right_in = '0;
    gain_l = 14'd16383; gain_r = 14'd16383;
    mute_pin = 1'b0; mute_reg = 1'b0; invert = 1'b0;
    mg[0] = 16383; mg[1] = 16383; zrun = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ramp();
    t_scale();
    t_invert();
    t_zero();
    t_mute_pin();
    t_unmute();
    t_mute_reg();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule